// File: doc/BRIEF.md
# Synthesiser Programming Port over I2C

This block is the serial control port of a frequency synthesiser. It watches the two I2C lines with a fast system clock and answers as a bus slave. Its 7-bit address has five fixed upper bits and two low bits taken from board straps. In write mode it turns incoming data bytes into the loop's programming state: a 15-bit divide ratio, a reference divider code, a charge pump current code, a test mode selection, two controls for the reference/comparison output and four port outputs. In read mode it returns a status byte that carries a power-on flag and the loop lock flag.

Data bytes carry no register address. The first byte of each pair tells the slave what the pair holds. A cleared leading bit opens a frequency pair and a set leading bit opens a control pair. The divide ratio is updated in one step, so a loop that is being fine-tuned never sees half of a new ratio. The data line is open-drain: the block gives an enable that pulls SDA low and never drives it high.

Top module: `synth_ctrl_if`

## Requirements
- R1: The slave answers only the address byte {1,1,0,0,0,addr_sel[1],addr_sel[0]} followed by the R/W bit, where R/W = 0 means write and R/W = 1 means read. It acknowledges a matching address by pulling SDA low for the ninth clock. A non-matching address is not acknowledged, and neither is any byte that follows it before the next START.
- R2: In write mode the slave acknowledges every complete data byte during that byte's ninth clock.
- R3: The first data byte of a pair with bit 7 = 0 holds ratio bits 14..8 in its bits 6..0. The byte after it holds ratio bits 7..0. freq_word changes only when that second byte arrives, and then all 15 bits change together.
- R4: A STOP that follows a lone frequency first byte moves its seven high bits into freq_word and keeps the previous low byte.
- R5: The first data byte of a pair with bit 7 = 1 sets test_en from bit 6 and ref_code from bits 3..0. test_sel takes bits 5..4 when bit 6 is 1 and reads 00 whenever test_en is 0.
- R6: The byte after a control first byte sets cp_sel from bits 7..6, ref_out_en from bit 5, ref_out_sel from bit 4 and port_out from bits 3..0.
- R7: Pairs of either kind may follow one another in a single write transfer without a new address. Each pair is decoded by the same leading-bit rule.
- R8: A STOP in the middle of a byte discards the partial byte and leaves every programmed output unchanged.
- R9: After reset, freq_word, ref_code, test_en, test_sel, cp_sel and port_out are 0 (ports off), ref_out_en and ref_out_sel are 1, and sda_oe is 0.
- R10: In read mode the status byte is sent MSB first as {POR, lock_i, 000000}. The slave pulls SDA low for each 0 bit and releases it for each 1 bit.
- R11: When the controller acknowledges a status byte, another status byte follows. When it does not, the slave stops driving SDA until the next START.
- R12: The POR flag is set by reset and stays set through write transfers. It clears only on a STOP that ends a transfer in which a status byte was sent.
- R13: sda_oe is 0 in the cycle after a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel | input | 2 | Strap value for the two low address bits |
| lock_i | input | 1 | Loop lock indication for the status byte |
| freq_word | output | FREQ_W | Programmable divide ratio |
| test_en | output | 1 | Test mode enable |
| test_sel | output | 2 | Test mode selection, 00 when disabled |
| ref_code | output | 4 | Reference divider ratio code |
| cp_sel | output | 2 | Charge pump current code |
| ref_out_en | output | 1 | Reference/comparison output enable |
| ref_out_sel | output | 1 | Reference/comparison output select |
| port_out | output | 4 | Switching port states, 1 = on |

## Verification
The assertions check, on every cycle, the rules that concern single events. SDA is pulled low only right after a falling SCL edge and is released after every STOP. The divide ratio moves only on a completed byte or a STOP, never anywhere else. The test selection reads 00 while test mode is off. The power-on flag never rises after reset and falls only on a STOP. Whether the bytes are decoded into the right fields, whether a lone high byte keeps the old low byte, whether a partial byte is thrown away, whether a foreign address is ignored, and what the status byte holds across acknowledged and refused reads can only be seen in the bench's transfer scenarios, which compare the outputs against a model of the pair rule.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_RD_NEXT
  } bus_state_t;

  // second byte of a control pair
  typedef struct packed {
    logic [1:0] cp;
    logic       re;
    logic       rs;
    logic [3:0] port;
  } ctrl_lo_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // bit 1 = SCL, bit 0 = SDA
  logic [1:0] pipe [STAGES];
  logic [1:0] prev;
  logic [1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= 2'b11;
      prev <= 2'b11;
    end else begin
      pipe[0] <= {scl_i, sda_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign cur       = pipe[STAGES-1];
  assign sda_s     = cur[0];
  assign scl_rise  = cur[1] & ~prev[1];
  assign scl_fall  = ~cur[1] & prev[1];
  assign start_det = cur[1] & prev[1] & prev[0] & ~cur[0];
  assign stop_det  = cur[1] & prev[1] & ~prev[0] & cur[0];
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import synth_i2c_pkg::*;
#(
  parameter int          ADDR_FIX_W = 5,
  parameter logic [4:0]  ADDR_FIX   = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  output logic              sda_oe,
  output logic              wr_begin,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data,
  output logic              por_flag
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  bus_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, match_q, rd_seen_q;
  logic [BYTE_W-1:0] shifted;
  logic [BYTE_W-1:0] status;
  logic [6:0]        own_addr;

  assign shifted  = {sh_q[BYTE_W-2:0], sda_s};
  assign status   = {por_flag, lock_i, 6'b000000};
  assign own_addr = {ADDR_FIX[ADDR_FIX_W-1:0], addr_sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      match_q   <= 1'b0;
      rd_seen_q <= 1'b0;
      por_flag  <= 1'b1;
      sda_oe    <= 1'b0;
      wr_begin  <= 1'b0;
      byte_stb  <= 1'b0;
      byte_data <= '0;
    end else begin
      wr_begin <= 1'b0;
      byte_stb <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
        cnt_q   <= '0;
        if (rd_seen_q) begin
          por_flag  <= 1'b0;
          rd_seen_q <= 1'b0;
        end
      end else if (start_det) begin
        state_q <= ST_ADDR;
        sda_oe  <= 1'b0;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise && cnt_q < FULL) begin
              sh_q  <= shifted;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST_BIT) begin
                if (state_q == ST_ADDR) begin
                  match_q <= (shifted[BYTE_W-1:1] == own_addr);
                  rw_q    <= shifted[0];
                end else begin
                  byte_stb  <= 1'b1;
                  byte_data <= shifted;
                end
              end
            end else if (scl_fall && cnt_q == FULL) begin
              if (state_q == ST_ADDR && !match_q) begin
                state_q <= ST_IDLE;
              end else begin
                sda_oe  <= 1'b1;
                state_q <= (state_q == ST_ADDR) ? ST_ADDR_ACK : ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q      <= status;
                sda_oe    <= ~status[BYTE_W-1];
                rd_seen_q <= 1'b1;
                state_q   <= ST_RD_DATA;
              end else begin
                sda_oe   <= 1'b0;
                wr_begin <= 1'b1;
                state_q  <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q != '0) begin
              if (cnt_q == FULL) begin
                sda_oe  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                sh_q   <= sh_q << 1;
                sda_oe <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) state_q <= sda_s ? ST_IDLE : ST_RD_NEXT;
          end
          ST_RD_NEXT: begin
            if (scl_fall) begin
              sh_q    <= status;
              sda_oe  <= ~status[BYTE_W-1];
              cnt_q   <= '0;
              state_q <= ST_RD_DATA;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_reg_decode.sv
module synth_reg_decode
  import synth_i2c_pkg::*;
#(
  parameter int FREQ_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_begin,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              stop_det,
  output logic [FREQ_W-1:0] freq_word,
  output logic              test_en,
  output logic [1:0]        test_sel,
  output logic [3:0]        ref_code,
  output logic [1:0]        cp_sel,
  output logic              ref_out_en,
  output logic              ref_out_sel,
  output logic [3:0]        port_out
);
  localparam int HI_W = FREQ_W - BYTE_W;

  logic [HI_W-1:0] hi_q;
  logic            pend_q;
  logic            second_q;
  logic            ctrl_pair_q;
  ctrl_lo_t        lo_fields;

  assign lo_fields = ctrl_lo_t'(byte_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_word   <= '0;
      hi_q        <= '0;
      pend_q      <= 1'b0;
      second_q    <= 1'b0;
      ctrl_pair_q <= 1'b0;
      test_en     <= 1'b0;
      test_sel    <= 2'b00;
      ref_code    <= 4'h0;
      cp_sel      <= 2'b00;
      ref_out_en  <= 1'b1;
      ref_out_sel <= 1'b1;
      port_out    <= 4'h0;
    end else if (wr_begin) begin
      second_q <= 1'b0;
    end else if (byte_stb) begin
      if (!second_q) begin
        second_q    <= 1'b1;
        ctrl_pair_q <= byte_data[BYTE_W-1];
        if (byte_data[BYTE_W-1]) begin
          test_en  <= byte_data[6];
          test_sel <= byte_data[6] ? byte_data[5:4] : 2'b00;
          ref_code <= byte_data[3:0];
        end else begin
          hi_q   <= byte_data[HI_W-1:0];
          pend_q <= 1'b1;
        end
      end else begin
        second_q <= 1'b0;
        if (ctrl_pair_q) begin
          cp_sel      <= lo_fields.cp;
          ref_out_en  <= lo_fields.re;
          ref_out_sel <= lo_fields.rs;
          port_out    <= lo_fields.port;
        end else begin
          freq_word <= {hi_q, byte_data};
          pend_q    <= 1'b0;
        end
      end
    end else if (stop_det && pend_q) begin
      freq_word <= {hi_q, freq_word[BYTE_W-1:0]};
      pend_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/synth_ctrl_if.sv
module synth_ctrl_if
  import synth_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_FIX    = 5'b11000,
  parameter int         FREQ_W      = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  output logic [FREQ_W-1:0] freq_word,
  output logic              test_en,
  output logic [1:0]        test_sel,
  output logic [3:0]        ref_code,
  output logic [1:0]        cp_sel,
  output logic              ref_out_en,
  output logic              ref_out_sel,
  output logic [3:0]        port_out
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_begin, byte_stb, por_flag;
  logic [BYTE_W-1:0] byte_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.ADDR_FIX_W(5), .ADDR_FIX(ADDR_FIX)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .lock_i(lock_i), .sda_oe(sda_oe),
    .wr_begin(wr_begin), .byte_stb(byte_stb), .byte_data(byte_data),
    .por_flag(por_flag)
  );

  synth_reg_decode #(.FREQ_W(FREQ_W)) u_dec (
    .clk(clk), .rst(rst), .wr_begin(wr_begin), .byte_stb(byte_stb),
    .byte_data(byte_data), .stop_det(stop_det), .freq_word(freq_word),
    .test_en(test_en), .test_sel(test_sel), .ref_code(ref_code),
    .cp_sel(cp_sel), .ref_out_en(ref_out_en), .ref_out_sel(ref_out_sel),
    .port_out(port_out)
  );
endmodule

// File: rtl/synth_ctrl_if_chk.sv
module synth_ctrl_if_chk #(
  parameter int FREQ_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              stop_det,
  input logic              byte_stb,
  input logic [FREQ_W-1:0] freq_word,
  input logic              test_en,
  input logic [1:0]        test_sel,
  input logic              por_flag
);
  // R13
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R2
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));

  // R3
  freq_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_word) |-> ($past(byte_stb) || $past(stop_det)));

  // R5
  test_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !test_en |-> (test_sel == 2'b00));

  // R12
  por_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(por_flag) |-> $past(stop_det));

  // R12
  por_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(por_flag));
endmodule

bind synth_ctrl_if synth_ctrl_if_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .stop_det(stop_det), .byte_stb(byte_stb), .freq_word(freq_word),
  .test_en(test_en), .test_sel(test_sel), .por_flag(por_flag)
);

// File: tb/tb_synth_ctrl_if.sv
module tb_synth_ctrl_if;
  localparam int HALF = 16;

  logic clk = 0, rst = 1, scl_m = 1, sda_m = 1, lock_i = 0;
  logic [1:0] addr_sel = 2'b10;
  logic sda_oe, test_en, ref_out_en, ref_out_sel;
  logic [14:0] freq_word;
  logic [1:0] test_sel, cp_sel;
  logic [3:0] ref_code, port_out;
  wire sda_line = sda_m & ~sda_oe;

  synth_ctrl_if dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .freq_word(freq_word),
    .test_en(test_en), .test_sel(test_sel), .ref_code(ref_code),
    .cp_sel(cp_sel), .ref_out_en(ref_out_en), .ref_out_sel(ref_out_sel),
    .port_out(port_out)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // bench model of the programmed state
  logic [14:0] m_freq = 0;
  logic [6:0]  m_hi = 0;
  logic        m_pend = 0, m_second = 0, m_ctrl = 0;
  logic [2:0]  m_test = 0;
  logic [3:0]  m_ref = 0, m_port = 0;
  logic [1:0]  m_cp = 0;
  logic        m_re = 1, m_rs = 1;
  logic [7:0]  txq [8];
  int          txn;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [2:0] t);
    return t[2] ? t[1:0] : 2'b00;
  endfunction

  task automatic model_byte(input logic [7:0] b);
    if (!m_second) begin
      m_second = 1; m_ctrl = b[7];
      if (b[7]) begin m_test = b[6:4]; m_ref = b[3:0]; end
      else begin m_hi = b[6:0]; m_pend = 1; end
    end else begin
      m_second = 0;
      if (m_ctrl) begin m_cp = b[7:6]; m_re = b[5]; m_rs = b[4]; m_port = b[3:0]; end
      else begin m_freq = {m_hi, b}; m_pend = 0; end
    end
  endtask

  task automatic model_stop();
    if (m_pend) begin m_freq = {m_hi, m_freq[7:0]}; m_pend = 0; end
  endtask

  task automatic check_all(input string req);
    chk({req, " freq_word"}, freq_word, m_freq);
    chk({req, " test_en"}, test_en, m_test[2]);
    chk({req, " test_sel"}, test_sel, exp_sel(m_test));
    chk({req, " ref_code"}, ref_code, m_ref);
    chk({req, " cp_sel"}, cp_sel, m_cp);
    chk({req, " ref_out_en"}, ref_out_en, m_re);
    chk({req, " ref_out_sel"}, ref_out_sel, m_rs);
    chk({req, " port_out"}, port_out, m_port);
  endtask

  task automatic hp();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hp(); scl_m = 1; hp(); scl_m = 0; repeat (4) @(negedge clk);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1; hp(); scl_m = 1;
    repeat (HALF/2) @(negedge clk);
    b = sda_line;
    repeat (HALF/2) @(negedge clk);
    scl_m = 0; repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~give_ack);
  endtask

  // full write transfer of txq[0..txn-1]; returns 1 if every byte was acknowledged
  task automatic do_write(input logic [1:0] sel, output logic all_ack);
    logic a;
    bus_start();
    send_byte({5'b11000, sel, 1'b0}, a);
    all_ack = a;
    for (int i = 0; i < txn; i++) begin send_byte(txq[i], a); all_ack &= a; end
    bus_stop();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] rb;
    logic [14:0] keep;
    void'($urandom(32'd5769));
    repeat (10) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);

    // R9 reset state
    check_all("R9");
    chk("R9 sda_oe", sda_oe, 0);

    // R3 atomic frequency update
    bus_start();
    send_byte({5'b11000, addr_sel, 1'b0}, a);
    chk("R1 own address ack", a, 1);
    send_byte(8'h55, a);
    chk("R2 data ack", a, 1);
    repeat (8) @(negedge clk);
    chk("R3 freq held after first byte", freq_word, 0);
    send_byte(8'hA3, a);
    bus_stop();
    repeat (8) @(negedge clk);
    model_byte(8'h55); model_byte(8'hA3); model_stop();
    chk("R3 freq committed", freq_word, 15'h55A3);

    // R5 R6 control pair with test mode on, then T2 clear
    txn = 2; txq[0] = 8'b1101_0110; txq[1] = 8'b1001_1010;
    do_write(addr_sel, ok);
    chk("R2 all acked", ok, 1);
    m_second = 0; model_byte(txq[0]); model_byte(txq[1]); model_stop();
    check_all("R5 R6");
    txn = 2; txq[0] = 8'b1011_0001; txq[1] = 8'b0110_0101;
    do_write(addr_sel, ok);
    m_second = 0; model_byte(txq[0]); model_byte(txq[1]); model_stop();
    chk("R5 test_sel gated", test_sel, 0);
    check_all("R5 R6 second");

    // R7 several pairs in one transfer
    txn = 6;
    txq[0] = 8'h12; txq[1] = 8'h34; txq[2] = 8'hC9; txq[3] = 8'hFF;
    txq[4] = 8'h7E; txq[5] = 8'h01;
    do_write(addr_sel, ok);
    chk("R7 all acked", ok, 1);
    m_second = 0;
    for (int i = 0; i < 6; i++) model_byte(txq[i]);
    model_stop();
    chk("R7 freq from last pair", freq_word, 15'h7E01);
    check_all("R7");

    // R4 lone high byte then STOP
    txn = 1; txq[0] = 8'h2B;
    do_write(addr_sel, ok);
    chk("R4 freq high only", freq_word, {7'h2B, 8'h01});
    m_second = 0; model_byte(txq[0]); model_stop();

    // R8 STOP in the middle of a byte
    keep = freq_word;
    bus_start();
    send_byte({5'b11000, addr_sel, 1'b0}, a);
    put_bit(0); put_bit(1); put_bit(1); put_bit(1);
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R8 partial byte discarded", freq_word, keep);
    check_all("R8");
    chk("R13 released after stop", sda_oe, 0);

    // R1 foreign address ignored, then strap change
    txn = 2; txq[0] = 8'h01; txq[1] = 8'h02;
    do_write(2'b01, ok);
    chk("R1 foreign address refused", ok, 0);
    check_all("R1 unchanged");
    addr_sel = 2'b01;
    repeat (4) @(negedge clk);
    do_write(2'b01, ok);
    chk("R1 new strap acked", ok, 1);
    m_second = 0; model_byte(txq[0]); model_byte(txq[1]); model_stop();
    check_all("R1 new strap");

    // constrained random write transfers
    for (int k = 0; k < 30; k++) begin
      int np;
      np = 1 + ($urandom % 3);
      txn = 0;
      for (int p = 0; p < np; p++) begin
        logic [14:0] r;
        r = 15'($urandom);
        if ($urandom % 2) begin txq[txn] = {1'b1, r[14:8]}; end
        else begin txq[txn] = {1'b0, r[14:8]}; end
        txq[txn+1] = r[7:0];
        txn += 2;
      end
      if (($urandom % 4) == 0) txn--;
      do_write(addr_sel, ok);
      chk("R2 random acks", ok, 1);
      m_second = 0;
      for (int i = 0; i < txn; i++) model_byte(txq[i]);
      model_stop();
      check_all("R7 random");
    end

    // R10 R12 status reads
    lock_i = 1;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte({5'b11000, addr_sel, 1'b1}, a);
    chk("R1 read address ack", a, 1);
    recv_byte(rb, 1'b1);
    chk("R12 POR kept through writes", rb, 8'hC0);
    recv_byte(rb, 1'b0);
    chk("R11 status repeats after ack", rb, 8'hC0);
    recv_byte(rb, 1'b0);
    chk("R11 silent after nack", rb, 8'hFF);
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R13 released", sda_oe, 0);

    bus_start();
    send_byte({5'b11000, addr_sel, 1'b1}, a);
    recv_byte(rb, 1'b0);
    chk("R12 POR cleared by stop", rb, 8'h40);
    bus_stop();
    lock_i = 0;
    repeat (8) @(negedge clk);
    bus_start();
    send_byte({5'b11000, addr_sel, 1'b1}, a);
    recv_byte(rb, 1'b0);
    chk("R10 status unlocked", rb, 8'h00);
    bus_stop();
    repeat (8) @(negedge clk);
    check_all("R10 reads leave state");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule